// File: doc/BRIEF.md
# Port-Addressed Pulse Width Modulator

This block hangs off the 8-bit port bus of a small microcontroller and drives one pulse-width-modulated output. Software sets the length of the high phase and the length of the low phase through two separate byte registers. Each register is written with a write strobe, a port address and a data byte. Either register can be read back with a read strobe. Each width is counted in ticks of a fixed enable input, `tick_en`, so a slower pulse rate comes from gating that input and needs no prescaler inside the block.

A three-state machine sequences the output. `S_IDLE` holds the output low while both widths are zero. `S_HIGH` drives the output high. `S_LOW` drives it low. The named transitions are:

- IDLE_TO_HIGH: a tick arrives while the high width is non-zero.
- IDLE_TO_LOW: a tick arrives while only the low width is non-zero.
- HIGH_TO_LOW: the last tick of a high phase, with a non-zero low width.
- HIGH_TO_HIGH: the last tick of a high phase, with a zero low width.
- HIGH_TO_IDLE: the last tick of a high phase, with both widths zero.
- LOW_TO_HIGH: the last tick of a low phase, with a non-zero high width.
- LOW_TO_LOW: the last tick of a low phase, with a zero high width.
- LOW_TO_IDLE: the last tick of a low phase, with both widths zero.

A phase copies its width into a down counter when it starts. For that reason a register write never alters a phase that is already running.

Top module: `pwm_port_periph`

## Requirements
- R1: While `rst_n` is low, `pwm_out` is 0 and both width registers are cleared, so both read back as 0x00 after reset.
- R2: A cycle with `wr_stb` high and `port_addr` = 0x00 loads `port_wdata` into the high-width register. With `port_addr` = 0x01 it loads the low-width register instead.
- R3: A write to any address other than 0x00 or 0x01 changes neither register. The registers also hold their values in every cycle without `wr_stb`.
- R4: A cycle with `rd_stb` high returns, on `port_rdata` from the next clock edge on, the value of the register at `port_addr`. Addresses other than 0x00 and 0x01 return 0x00. `port_rdata` holds its value between reads.
- R5: When both widths are non-zero, `pwm_out` repeats a pattern of high for exactly H ticks followed by low for exactly L ticks, where H and L are the two register values.
- R6: The phase counter advances only in cycles with `tick_en` high. With `tick_en` low the output never changes.
- R7: A new width value takes effect only at the next phase boundary. A phase that is already running keeps the length it started with.
- R8: A zero width skips its phase. With H = 0 and L > 0 the output stays low. With H > 0 and L = 0 it stays high.
- R9: With both widths zero the output holds low. Once a non-zero high width is written, the output rises on the first tick after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count enable; one tick per cycle in which it is high |
| port_addr | input | 8 | Port address for reads and writes |
| port_wdata | input | 8 | Write data from the processor |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| port_rdata | output | 8 | Read data to the processor, registered |
| pwm_out | output | 1 | Pulse-width-modulated output |

## Verification
The hardest case to reach from the ports is a width change that arrives in the middle of a running phase, because the write has to land strictly between two phase boundaries. The bench programs a long high phase and waits for the rising edge. It counts a few cycles and then writes a short value. It then measures that the current high phase still has its original length and that only the following high phase is short. The zero-width transitions into and out of idle are reached by a sweep over every pairing of a small set of widths that includes zero.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Phase state of the modulator
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HIGH = 2'd1,
        S_LOW  = 2'd2
    } pwm_state_e;

    // Register selects decoded from the port address
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_HI   = 2'd1,
        SEL_LO   = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/pwm_port_regs.sv
module pwm_port_regs
    import pwm_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int HI_ADDR = 0,
    parameter int LO_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic [DATA_W-1:0] port_wdata,
    input  logic              wr_stb,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] port_rdata,
    output logic [DATA_W-1:0] hi_width,
    output logic [DATA_W-1:0] lo_width
);

    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);

    reg_sel_e          sel;
    logic [DATA_W-1:0] rd_mux;

    // Address decode
    always_comb begin
        if (port_addr == HI_A) begin
            sel = SEL_HI;
        end else if (port_addr == LO_A) begin
            sel = SEL_LO;
        end else begin
            sel = SEL_NONE;
        end
    end

    // Width registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_width <= '0;
            lo_width <= '0;
        end else if (wr_stb) begin
            unique case (sel)
                SEL_HI:   hi_width <= port_wdata;
                SEL_LO:   lo_width <= port_wdata;
                default:  ;
            endcase
        end
    end

    // Read mux
    always_comb begin
        unique case (sel)
            SEL_HI:  rd_mux = hi_width;
            SEL_LO:  rd_mux = lo_width;
            default: rd_mux = '0;
        endcase
    end

    // Registered read data, held between reads
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_rdata <= '0;
        end else if (rd_stb) begin
            port_rdata <= rd_mux;
        end
    end

    // R2
    hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && port_addr == HI_A) |=> (hi_width == $past(port_wdata)));

    // R2
    lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && port_addr == LO_A) |=> (lo_width == $past(port_wdata)));

    // R3
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb || (port_addr != HI_A && port_addr != LO_A))
            |=> ($stable(hi_width) && $stable(lo_width)));

    // R4
    bad_addr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && port_addr != HI_A && port_addr != LO_A) |=> (port_rdata == '0));

    // R4
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(port_rdata));

endmodule

// File: rtl/pwm_phase_counter.sv
module pwm_phase_counter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              dec,
    output logic [DATA_W-1:0] cnt,
    output logic              last
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - ONE;
        end
    end

    assign last = (cnt == ONE);

endmodule

// File: rtl/pwm_phase_fsm.sv
module pwm_phase_fsm
    import pwm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [DATA_W-1:0] hi_width,
    input  logic [DATA_W-1:0] lo_width,
    output logic              pwm_out
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    pwm_state_e        state;
    pwm_state_e        state_nx;
    logic              load;
    logic [DATA_W-1:0] load_val;
    logic              dec;
    logic [DATA_W-1:0] cnt;
    logic              last;
    logic              hi_nz;
    logic              lo_nz;
    logic              bound;

    assign hi_nz = (hi_width != '0);
    assign lo_nz = (lo_width != '0);
    assign bound = tick_en && (state != S_IDLE) && last;

    pwm_phase_counter #(
        .DATA_W (DATA_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .dec      (dec),
        .cnt      (cnt),
        .last     (last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state and counter control
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        load_val = '0;
        unique case (state)
            S_IDLE: begin
                if (tick_en) begin
                    if (hi_nz) begin
                        state_nx = S_HIGH;   // IDLE_TO_HIGH
                        load     = 1'b1;
                        load_val = hi_width;
                    end else if (lo_nz) begin
                        state_nx = S_LOW;    // IDLE_TO_LOW
                        load     = 1'b1;
                        load_val = lo_width;
                    end
                end
            end
            S_HIGH: begin
                if (bound) begin
                    if (lo_nz) begin
                        state_nx = S_LOW;    // HIGH_TO_LOW
                        load     = 1'b1;
                        load_val = lo_width;
                    end else if (hi_nz) begin
                        state_nx = S_HIGH;   // HIGH_TO_HIGH
                        load     = 1'b1;
                        load_val = hi_width;
                    end else begin
                        state_nx = S_IDLE;   // HIGH_TO_IDLE
                    end
                end
            end
            S_LOW: begin
                if (bound) begin
                    if (hi_nz) begin
                        state_nx = S_HIGH;   // LOW_TO_HIGH
                        load     = 1'b1;
                        load_val = hi_width;
                    end else if (lo_nz) begin
                        state_nx = S_LOW;    // LOW_TO_LOW
                        load     = 1'b1;
                        load_val = lo_width;
                    end else begin
                        state_nx = S_IDLE;   // LOW_TO_IDLE
                    end
                end
            end
            default: state_nx = S_IDLE;
        endcase
    end

    assign dec = tick_en && (state != S_IDLE) && !last;

    // Output decode from the state register
    always_comb begin
        unique case (state)
            S_HIGH:  pwm_out = 1'b1;
            default: pwm_out = 1'b0;
        endcase
    end

    // R8
    active_cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> (cnt != '0));

    // R6
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(state) && $stable(cnt)));

    // R7
    mid_phase_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && tick_en && cnt > ONE)
            |=> (state == $past(state) && cnt == $past(cnt) - ONE));

    // R9
    both_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !hi_nz && !lo_nz && (state == S_IDLE || last)) |=> (state == S_IDLE));

endmodule

// File: rtl/pwm_port_periph.sv
module pwm_port_periph #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int HI_ADDR = 0,
    parameter int LO_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic [DATA_W-1:0] port_wdata,
    input  logic              wr_stb,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] port_rdata,
    output logic              pwm_out
);

    logic [DATA_W-1:0] hi_width;
    logic [DATA_W-1:0] lo_width;

    pwm_port_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .HI_ADDR (HI_ADDR),
        .LO_ADDR (LO_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_addr  (port_addr),
        .port_wdata (port_wdata),
        .wr_stb     (wr_stb),
        .rd_stb     (rd_stb),
        .port_rdata (port_rdata),
        .hi_width   (hi_width),
        .lo_width   (lo_width)
    );

    pwm_phase_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .hi_width (hi_width),
        .lo_width (lo_width),
        .pwm_out  (pwm_out)
    );

    // R8
    rise_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> ($past(hi_width) != '0));

    // R1
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |-> !pwm_out);

endmodule

// File: tb/pwm_port_periph_bench.sv
module pwm_port_periph_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic [7:0] port_addr = 8'h00;
    logic [7:0] port_wdata = 8'h00;
    logic       wr_stb = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] port_rdata;
    logic       pwm_out;

    int n_tests = 0;
    int n_fail  = 0;
    int tick_mode = 0;  // 0: always on, 1: every other cycle, 2: held off

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (tick_mode == 0)      tick_en = 1'b1;
        else if (tick_mode == 1) tick_en = ~tick_en;
        else                     tick_en = 1'b0;
    end

    pwm_port_periph u_pwm_port_periph (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .port_addr  (port_addr),
        .port_wdata (port_wdata),
        .wr_stb     (wr_stb),
        .rd_stb     (rd_stb),
        .port_rdata (port_rdata),
        .pwm_out    (pwm_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        port_addr = a; port_wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic read_reg(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        port_addr = a; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        d = port_rdata;
    endtask

    // Wait for a rising edge seen at negedge sampling; returns 0 on timeout
    task automatic wait_rise(output bit found);
        logic prev;
        found = 1'b0;
        prev = pwm_out;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (pwm_out && !prev) begin
                found = 1'b1;
                break;
            end
            prev = pwm_out;
        end
    endtask

    // Called right after a rise: length of high run, then low run
    task automatic measure(output int hl, output int ll);
        hl = 1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (pwm_out) hl++; else break;
        end
        ll = 1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!pwm_out) ll++; else break;
        end
    endtask

    task automatic window_const(input logic v, input int len, output int bad);
        bad = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (pwm_out !== v) bad++;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        bit found;
        int hl, ll, bad;
        int widths [5] = '{0, 1, 2, 3, 7};

        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R1 output low in reset", pwm_out, 0);
        rst_n = 1'b1;
        read_reg(8'h00, rd);
        check(rd == 8'h00, "R1 high reg after reset", rd, 0);
        read_reg(8'h01, rd);
        check(rd == 8'h00, "R1 low reg after reset", rd, 0);
        window_const(1'b0, 20, bad);
        check(bad == 0, "R9 idle low after reset", bad, 0);

        // R2 / R4 readback
        write_reg(8'h00, 8'hA5);
        write_reg(8'h01, 8'h3C);
        read_reg(8'h00, rd);
        check(rd == 8'hA5, "R2 high reg write", rd, 8'hA5);
        read_reg(8'h01, rd);
        check(rd == 8'h3C, "R2 low reg write", rd, 8'h3C);
        @(negedge clk);
        check(port_rdata == 8'h3C, "R4 rdata holds between reads", port_rdata, 8'h3C);

        // R3 / R4 other addresses
        for (int a = 2; a < 256; a += 37) begin
            write_reg(8'(a), 8'hFF);
            read_reg(8'(a), rd);
            check(rd == 8'h00, "R4 unmapped reads zero", rd, 0);
        end
        read_reg(8'h00, rd);
        check(rd == 8'hA5, "R3 high reg untouched", rd, 8'hA5);
        read_reg(8'h01, rd);
        check(rd == 8'h3C, "R3 low reg untouched", rd, 8'h3C);
        @(negedge clk);
        port_addr = 8'h00; port_wdata = 8'h11;
        repeat (3) @(negedge clk);
        read_reg(8'h00, rd);
        check(rd == 8'hA5, "R3 no write without strobe", rd, 8'hA5);

        // Return to idle
        write_reg(8'h00, 8'h00);
        write_reg(8'h01, 8'h00);
        repeat (600) @(negedge clk);
        window_const(1'b0, 30, bad);
        check(bad == 0, "R9 both zero holds low", bad, 0);
        write_reg(8'h00, 8'h04);
        @(negedge clk);
        check(pwm_out == 1'b1, "R9 rise on first tick after write", pwm_out, 1);

        // R5 / R8 sweep
        foreach (widths[i]) begin
            foreach (widths[j]) begin
                write_reg(8'h00, 8'(widths[i]));
                write_reg(8'h01, 8'(widths[j]));
                if (widths[i] != 0 && widths[j] != 0) begin
                    wait_rise(found);
                    check(found, "R5 rise seen", found, 1);
                    wait_rise(found);
                    measure(hl, ll);
                    check(hl == widths[i], "R5 high length", hl, widths[i]);
                    check(ll == widths[j], "R5 low length", ll, widths[j]);
                end else if (widths[i] == 0) begin
                    repeat (40) @(negedge clk);
                    window_const(1'b0, 30, bad);
                    check(bad == 0, "R8 zero high stays low", bad, 0);
                end else begin
                    repeat (40) @(negedge clk);
                    window_const(1'b1, 30, bad);
                    check(bad == 0, "R8 zero low stays high", bad, 0);
                end
            end
        end

        // R6 half-rate ticks
        write_reg(8'h00, 8'h03);
        write_reg(8'h01, 8'h05);
        tick_mode = 1;
        wait_rise(found);
        wait_rise(found);
        measure(hl, ll);
        check(hl == 6, "R6 half-rate high", hl, 6);
        check(ll == 10, "R6 half-rate low", ll, 10);
        tick_mode = 2;
        repeat (2) @(negedge clk);
        begin
            logic held;
            held = pwm_out;
            window_const(held, 50, bad);
            check(bad == 0, "R6 frozen without ticks", bad, 0);
        end
        tick_mode = 0;

        // R7 mid-phase change
        write_reg(8'h00, 8'd20);
        write_reg(8'h01, 8'd4);
        wait_rise(found);
        wait_rise(found);
        hl = 1;
        repeat (4) begin
            @(negedge clk);
            if (pwm_out) hl++;
        end
        write_reg(8'h00, 8'd3);
        hl += 2;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (pwm_out) hl++; else break;
        end
        check(hl == 20, "R7 running phase keeps length", hl, 20);
        ll = 1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!pwm_out) ll++; else break;
        end
        check(ll == 4, "R7 low unchanged", ll, 4);
        measure(hl, ll);
        check(hl == 3, "R7 next phase uses new width", hl, 3);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(pwm_out == 1'b0, "R1 reset drives low", pwm_out, 0);
        rst_n = 1'b1;
        read_reg(8'h00, rd);
        check(rd == 8'h00, "R1 reset clears high reg", rd, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule